// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Master

This block is a serial master for command/response links where one wire carries data out and another carries data in. A frame is only ever in one direction at a time. The parallel side hands over a request: an 8-bit command and a reply length. The block then runs the frame on its own. It generates the serial clock and holds the frame select active. It shifts the command out most significant bit first, then leaves one idle serial clock so the slave can turn the link around. After that it shifts in a reply of 4 to 16 bits, also most significant bit first. The received word comes back as a right-justified value with a one-cycle valid pulse.

Requests use a valid/ready handshake. `req_ready` is high only while no frame is in progress, so a request is taken on any cycle with both `req_valid` and `req_ready` high. While a frame runs, `req_ready` stays low and `req_valid` has no effect. The reply side has no back-pressure: `rsp_valid` is a single-cycle pulse that the consumer must take when it appears. The serial clock comes from an even divider of the system clock. The half-period in system cycles is set by `div_half` and latched when the request is accepted.

Top module: `mw_master`

## Requirements
- R1: After reset, `sclk`, `cs`, `sdo_oe`, `busy` and `rsp_valid` are low and `req_ready` is high.
- R2: A request is accepted only on a cycle where both `req_valid` and `req_ready` are high. From the next cycle `busy` is high and `req_ready` is low. A `req_valid` seen while busy changes neither the running frame nor the state after it, and no second frame starts.
- R3: The 8 command bits leave on `sdo`, most significant bit first, with `sdo_oe` high. Each bit is set up while `sclk` is low and holds steady for the whole high phase, so the slave can sample it on the rising edge.
- R4: The level on `sdi` during the command bits and the turnaround has no effect on `rsp_data`.
- R5: Between the last command bit and the first reply bit there is exactly one serial clock pulse, with `sdo_oe` low. `sdo_oe` stays low from then to the end of the frame.
- R6: The reply length is `req_len` limited to the range 4 to 16. Values below 4 act as 4 and values above 16 act as 16. A frame has exactly 9 + length rising edges of `sclk`.
- R7: Reply bits are sampled from `sdi` at the falling edge of `sclk`, most significant bit first. They are placed right-justified in `rsp_data`, with all unused upper bits zero.
- R8: `cs` goes high in the cycle after acceptance and stays high through the cycle in which `rsp_valid` is high. It is low in the cycle after that.
- R9: Each high phase and each low phase of `sclk` lasts H system cycles, where H is `div_half`, or 1 when `div_half` is 0. `sclk` is low whenever `cs` is low. So `cs` is high for (9 + length) * 2H + 1 cycles.
- R10: `rsp_valid` is high for exactly one cycle per frame. `busy` is still high in that cycle and low in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (no frame in progress) |
| req_cmd | input | 8 | Command byte to send |
| req_len | input | 5 | Reply length in bits, limited to 4..16 |
| div_half | input | 8 | Serial clock half-period in system cycles (0 acts as 1) |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the reply |
| rsp_data | output | 16 | Received reply, right-justified |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock, idle low |
| cs | output | 1 | Frame select, active high |
| sdo | output | 1 | Serial data to the slave |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data from the slave |

## Verification
The hardest case to reach from the ports is a request that arrives while a frame is already running. The test has to show that this request leaves no trace: the current reply is unchanged and no extra frame starts afterwards. The bench raises `req_valid` with a different command and length partway through a frame and holds it for several cycles. It then checks that `req_ready` is low, that the rising-edge count and the reply match the first request, and that the link stays idle once the frame ends. A behavioural slave drives `sdi` high during the command and the turnaround in some frames and low in others. This is what shows that the reply samples only the bits after the turnaround.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_TURN,
    ST_RESP,
    ST_DONE
  } mw_state_e;
endpackage

// File: rtl/mw_sclk_gen.sv
module mw_sclk_gen #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              sclk,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;
  logic              lvl_q;

  // tick marks the last system cycle of the current half-phase
  assign tick = en && (cnt_q == half - HALF_W'(1));
  assign sclk = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mw_tx_shift.sv
module mw_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= din;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] data
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (clr)    sr_q <= '0;
    else if (sample) sr_q <= {sr_q[W-2:0], din};
  end

  assign data = sr_q;
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int RSP_MIN = 4,
  parameter int RSP_MAX = 16,
  parameter int HALF_W  = 8,
  localparam int LEN_W  = $clog2(RSP_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CMD_W-1:0]   req_cmd,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [HALF_W-1:0]  div_half,
  output logic               rsp_valid,
  output logic [RSP_MAX-1:0] rsp_data,
  output logic               busy,
  output logic               sclk,
  output logic               cs,
  output logic               sdo,
  output logic               sdo_oe,
  input  logic               sdi
);
  localparam int CNT_W = (CMD_W > RSP_MAX) ? $clog2(CMD_W + 1) : LEN_W;

  mw_state_e          st_q;
  logic [LEN_W-1:0]   len_q, len_c;
  logic [HALF_W-1:0]  half_q, half_c;
  logic [CNT_W-1:0]   bit_q;
  logic               accept, run, tick, fall, tx_msb;
  logic [RSP_MAX-1:0] rx_data;

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign run    = (st_q == ST_CMD) || (st_q == ST_TURN) || (st_q == ST_RESP);
  assign fall   = tick && sclk;

  always_comb begin
    if (req_len < LEN_W'(RSP_MIN))      len_c = LEN_W'(RSP_MIN);
    else if (req_len > LEN_W'(RSP_MAX)) len_c = LEN_W'(RSP_MAX);
    else                                len_c = req_len;
    half_c = (div_half == '0) ? HALF_W'(1) : div_half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= LEN_W'(RSP_MIN);
      half_q <= HALF_W'(1);
      bit_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_CMD;
          len_q  <= len_c;
          half_q <= half_c;
          bit_q  <= '0;
        end
        ST_CMD: if (fall) begin
          if (bit_q == CNT_W'(CMD_W - 1)) begin
            st_q  <= ST_TURN;
            bit_q <= '0;
          end else begin
            bit_q <= bit_q + CNT_W'(1);
          end
        end
        ST_TURN: if (fall) st_q <= ST_RESP;
        ST_RESP: if (fall) begin
          if (bit_q == CNT_W'(len_q) - CNT_W'(1)) st_q <= ST_DONE;
          else                                   bit_q <= bit_q + CNT_W'(1);
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  mw_sclk_gen #(.HALF_W(HALF_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(run), .half(half_q), .sclk(sclk), .tick(tick)
  );

  mw_tx_shift #(.W(CMD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(req_cmd),
    .shift(fall && (st_q == ST_CMD)), .msb(tx_msb)
  );

  mw_rx_shift #(.W(RSP_MAX)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .sample(fall && (st_q == ST_RESP)), .din(sdi), .data(rx_data)
  );

  assign busy      = (st_q != ST_IDLE);
  assign req_ready = !busy;
  assign cs        = busy;
  assign sdo_oe    = (st_q == ST_CMD);
  assign sdo       = sdo_oe ? tx_msb : 1'b0;
  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_data  = rx_data;
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic rsp_valid,
  input logic sclk,
  input logic cs,
  input logic sdo,
  input logic sdo_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!sclk && !sdo_oe)); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R2
  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && sdo_oe) |-> $stable(sdo)); // R3
  AST_OE_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> (cs && !sclk)); // R5
  AST_CS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |-> $past(rsp_valid)); // R8
  AST_VALID_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy)); // R10
endmodule

bind mw_master mw_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .rsp_valid(rsp_valid), .sclk(sclk), .cs(cs), .sdo(sdo),
  .sdo_oe(sdo_oe)
);

// File: tb/mw_master_tb.sv
module mw_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cmd = '0;
  logic [4:0]  req_len = 5'd4;
  logic [7:0]  div_half = 8'd1;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        busy, sclk, cs, sdo, sdo_oe;
  logic        sdi = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  mw_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_len(req_len), .div_half(div_half),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .sclk(sclk),
    .cs(cs), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  // behavioural slave
  int          rises = 0;
  logic [7:0]  cap = '0;
  bit          oe_bad = 0;
  logic [15:0] slv_resp = '0;
  int          slv_len = 4;
  logic        noise = 1'b0;
  int          cs_cyc = 0;
  int          v_cyc = 0;

  always @(posedge sclk) begin
    rises = rises + 1;
    if (rises <= 8) begin
      cap = {cap[6:0], sdo};
      if (!sdo_oe) oe_bad = 1;
    end else if (sdo_oe) begin
      oe_bad = 1;
    end
    if (rises >= 10 && (rises - 10) < slv_len)
      sdi <= slv_resp[slv_len - 1 - (rises - 10)];
    else
      sdi <= noise;
  end

  always @(negedge clk) begin
    if (cs) cs_cyc++;
    if (rsp_valid) v_cyc++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(sclk == 0, "R1", "sclk", sclk, 0);
    chk(cs == 0, "R1", "cs", cs, 0);
    chk(sdo_oe == 0, "R1", "sdo_oe", sdo_oe, 0);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
  endtask

  task automatic t_frame(input logic [7:0] cmd, input logic [4:0] len,
                         input logic [15:0] resp, input logic [7:0] half,
                         input logic nz, input int exp_len, input int exp_half,
                         input bit poke);
    logic [15:0] exp_data;
    int          guard;
    int          rises_end;
    exp_data = resp & 16'((32'd1 << exp_len) - 1);
    rises = 0; cap = '0; oe_bad = 0; cs_cyc = 0; v_cyc = 0;
    slv_resp = resp; slv_len = exp_len; noise = nz; sdi = nz;
    @(negedge clk);
    chk(req_ready == 1, "R2", "ready before request", req_ready, 1);
    req_valid = 1; req_cmd = cmd; req_len = len; div_half = half;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1 && req_ready == 0, "R2", "busy after accept", busy, 1);
    chk(cs == 1, "R8", "cs after accept", cs, 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      req_valid = 1; req_cmd = ~cmd; req_len = 5'd16; div_half = 8'd1;
      chk(req_ready == 0, "R2", "ready during frame", req_ready, 0);
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    guard = 0;
    while (!rsp_valid && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid == 1, "R10", "valid seen", rsp_valid, 1);
    chk(rsp_data == exp_data, nz ? "R4" : "R7", "rsp_data", rsp_data, exp_data);
    chk(busy == 1 && cs == 1, "R10", "busy in valid cycle", busy, 1);
    @(negedge clk);
    chk(busy == 0 && rsp_valid == 0, "R10", "busy after valid", busy, 0);
    chk(cs == 0, "R8", "cs after valid", cs, 0);
    chk(v_cyc == 1, "R10", "valid cycles", v_cyc, 1);
    chk(rises == 9 + exp_len, "R6", "sclk rises", rises, 9 + exp_len);
    chk(cap == cmd, "R3", "command captured", cap, cmd);
    chk(oe_bad == 0, "R5", "oe pattern", oe_bad, 0);
    chk(cs_cyc == (9 + exp_len) * 2 * exp_half + 1, "R9", "cs cycles",
        cs_cyc, (9 + exp_len) * 2 * exp_half + 1);
    if (poke) begin
      rises_end = rises;
      repeat (40) @(negedge clk);
      chk(busy == 0 && rises == rises_end, "R2", "no extra frame", rises, rises_end);
    end
  endtask

  initial begin
    repeat (800000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_frame(8'hA5, 5'd8,  16'h00C3, 8'd2, 1'b0, 8,  2, 0);
    t_frame(8'h3C, 5'd4,  16'h000A, 8'd1, 1'b1, 4,  1, 0);
    t_frame(8'hF0, 5'd16, 16'hBEEF, 8'd3, 1'b1, 16, 3, 0);
    t_frame(8'h81, 5'd2,  16'h0005, 8'd2, 1'b0, 4,  2, 0); // R6 low clamp
    t_frame(8'h5A, 5'd20, 16'h1234, 8'd1, 1'b0, 16, 1, 0); // R6 high clamp
    t_frame(8'h69, 5'd9,  16'h01A7, 8'd0, 1'b1, 9,  1, 0); // R9 zero divider
    t_frame(8'hC3, 5'd12, 16'h0ABC, 8'd2, 1'b1, 12, 2, 1); // R2 ignored request
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule